// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges reset requests from seven origins into a single system reset on the oscillator clock. The origins are power-on, an active-low external reset pin, low-voltage detection, watchdog overflow, overflow of the CPU-operation detection counter, a clock-supervisor fault, and a firmware write. The block also keeps a sticky flag for each origin so firmware can find out why the chip restarted.

The power-on, pin and low-voltage requests are asynchronous. Each one asserts the reset at once and is released through a synchronizer. Power-on is the only origin that adds an oscillator settling wait of 2^WAIT_LOG2 clock periods. The other origins release after a short fixed hold of HOLD_CYC cycles.

Every reset, whatever its origin, loads the two-bit settling-wait select field with all ones. Firmware requests a reset by writing 0 to a one-bit control register, and that bit reads 1 again once the reset is under way.

Top module: `sysreset_hub`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `cause_flags` is 7'b0000001, `ws_sel` is 2'b11 and `sw_bit` is 1.
- R2: After `por_n` rises, `sys_rst` stays 1 through the 65537th rising clock edge and is 0 after the 65538th: 2 synchronizer edges plus a 2^16-cycle wait.
- R3: A watchdog, CPU-detection or clock-supervisor request sampled high at edge e drives `sys_rst` to 1 after e. If e is the last edge at which it is sampled high, `sys_rst` stays 1 through edge e+7 and falls after edge e+8.
- R4: A low on `ext_rst_n` or a high on `lvd_det` drives `sys_rst` to 1 at once, with no clock edge needed. After the request is removed, `sys_rst` falls after the 10th rising edge: 2 synchronizer edges plus an 8-cycle hold.
- R5: The bits of `cause_flags` are, in order from bit 0: power-on, watchdog, external pin, software, low voltage, CPU detection, clock supervisor.
  - A flag is set at the first edge at which its origin is active.
  - A flag is cleared at an edge where its bit of `cause_clr` is 1, unless its origin is active at that same edge, in which case set wins.
  - Power-on sets bit 0 and clears all other flags.
- R6: `ws_sel` takes `ws_wdata` at an edge where `ws_wr` is 1 and no reset is active. At every edge during an active reset it is loaded with 2'b11, and writes made then are ignored.
- R7: A firmware reset request is `sw_wr`=1 with `sw_wdata`=0 while no reset is active. It takes effect as follows:
  - After that edge, `sys_rst` is 1, `sw_bit` is 0 and cause flag bit 3 is set.
  - `sw_bit` returns to 1 one edge later.
  - `sys_rst` falls 8 edges after the write.
  - Writing 1, or writing 0 while a reset is active, has no effect on `sys_rst` or the flags.
- R8: A power-on request that arrives during a running power-on wait restarts the full wait from its own release.
- R9: A new non-power-on request during a running hold restarts the 8-cycle hold from the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on request, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| lvd_det | input | 1 | Low-voltage detected, active high, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow, synchronous level |
| cpu_det_ovf | input | 1 | CPU-operation detection counter overflow, synchronous |
| clk_sup_fail | input | 1 | Clock supervisor fault, synchronous |
| sw_wr | input | 1 | Write strobe of the firmware reset bit |
| sw_wdata | input | 1 | Value written to the firmware reset bit |
| sw_bit | output | 1 | Read-back of the firmware reset bit |
| ws_wr | input | 1 | Write strobe of the wait-select field |
| ws_wdata | input | WS_W | Value written to the wait-select field |
| ws_sel | output | WS_W | Settling-wait select field |
| cause_clr | input | 7 | Per-flag clear mask |
| cause_flags | output | 7 | Sticky reset-cause flags |
| sys_rst | output | 1 | System reset, active high |

## Verification
Different results are due at different times:
- The pin and low-voltage requests raise `sys_rst` between clock edges, so those results are sampled a few nanoseconds after the input changes.
- A synchronous request raises `sys_rst` one edge later and releases it 8 edges after its last active edge.
- The asynchronous requests release 10 edges after removal, and power-on releases 65538 edges after removal.

The bench counts rising edges and samples every output on the falling edge after the edge number at which a result is due. A behavioural model tracks the remaining synchronizer, hold and wait time as integers and is compared with the outputs on every falling edge.

// File: rtl/sysreset_pkg.sv
package sysreset_pkg;
   // reset origins, bit positions of the cause flag vector
   localparam int NSRC    = 7;
   localparam int SRC_POR = 0;
   localparam int SRC_WDT = 1;
   localparam int SRC_EXT = 2;
   localparam int SRC_SW  = 3;
   localparam int SRC_LVD = 4;
   localparam int SRC_CPU = 5;
   localparam int SRC_CLK = 6;

   // asynchronous request slots feeding the synchronizer bank
   localparam int NASYNC  = 3;
   localparam int A_POR   = 0;
   localparam int A_EXT   = 1;
   localparam int A_LVD   = 2;

   typedef logic [NSRC-1:0]   src_vec_t;
   typedef logic [NASYNC-1:0] async_vec_t;
endpackage

// File: rtl/srh_sync.sv
// Reset bridge: asserts asynchronously, releases after STAGES clock edges.
module srh_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic req_a,
   output logic req_s
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge req_a) begin
      if (req_a) chain <= '1;
      else       chain <= {chain[STAGES-2:0], 1'b0};
   end

   assign req_s = chain[STAGES-1];
endmodule

// File: rtl/srh_stretch.sv
// Holds its output for HOLD_CYC cycles after the last trigger.
module srh_stretch #(
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (trig)           remain <= LOAD;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign active = (remain != '0);
endmodule

// File: rtl/srh_por_wait.sv
// Oscillator settling wait: counts 2^WAIT_LOG2 cycles after hold_in drops.
module srh_por_wait #(
   parameter int WAIT_LOG2 = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_in,
   output logic busy
);
   localparam int CW = WAIT_LOG2 + 1;

   logic [CW-1:0] cnt;
   logic          done;

   assign done = cnt[CW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (hold_in) cnt <= '0;
      else if (!done)   cnt <= cnt + 1'b1;
   end

   assign busy = hold_in | ~done;
endmodule

// File: rtl/srh_cause.sv
// Sticky cause flags; the POR_IDX bit comes up set on power-on.
module srh_cause #(
   parameter int N       = 7,
   parameter int POR_IDX = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      localparam logic RST_VAL = (i == POR_IDX) ? 1'b1 : 1'b0;
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q <= RST_VAL;
         else if (set_vec[i]) flag_q <= 1'b1;
         else if (clr_vec[i]) flag_q <= 1'b0;
      end
      assign flags[i] = flag_q;
   end
endmodule

// File: rtl/sysreset_hub.sv
module sysreset_hub
   import sysreset_pkg::*;
#(
   parameter int WAIT_LOG2   = 16,
   parameter int HOLD_CYC    = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WS_W        = 2
) (
   input  logic            osc_clk,
   input  logic            por_n,
   input  logic            ext_rst_n,
   input  logic            lvd_det,
   input  logic            wdt_ovf,
   input  logic            cpu_det_ovf,
   input  logic            clk_sup_fail,
   input  logic            sw_wr,
   input  logic            sw_wdata,
   output logic            sw_bit,
   input  logic            ws_wr,
   input  logic [WS_W-1:0] ws_wdata,
   output logic [WS_W-1:0] ws_sel,
   input  logic [NSRC-1:0] cause_clr,
   output logic [NSRC-1:0] cause_flags,
   output logic            sys_rst
);
   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (WAIT_LOG2 < 1 || WAIT_LOG2 > 30) begin : g_bad_wait
      $error("WAIT_LOG2 out of range");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("HOLD_CYC must be at least 1");
   end
   if (WS_W < 1) begin : g_bad_ws
      $error("WS_W must be at least 1");
   end

   async_vec_t async_raw;
   async_vec_t async_s;
   src_vec_t   trig_vec;
   logic       por_busy;
   logic       hold_act;
   logic       rst_int;
   logic       sw_fire;

   assign async_raw[A_POR] = ~por_n;
   assign async_raw[A_EXT] = ~ext_rst_n;
   assign async_raw[A_LVD] = lvd_det;

   // one reset bridge per asynchronous origin
   for (genvar g = 0; g < NASYNC; g++) begin : g_async
      srh_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (osc_clk),
         .req_a (async_raw[g]),
         .req_s (async_s[g])
      );
   end

   srh_por_wait #(.WAIT_LOG2(WAIT_LOG2)) u_wait (
      .clk     (osc_clk),
      .rst_n   (por_n),
      .hold_in (async_s[A_POR]),
      .busy    (por_busy)
   );

   // a firmware request is honoured only outside reset
   assign sw_fire = sw_wr & ~sw_wdata & ~rst_int;

   always_comb begin
      trig_vec          = '0;
      trig_vec[SRC_WDT] = wdt_ovf;
      trig_vec[SRC_EXT] = async_s[A_EXT];
      trig_vec[SRC_SW]  = sw_fire;
      trig_vec[SRC_LVD] = async_s[A_LVD];
      trig_vec[SRC_CPU] = cpu_det_ovf;
      trig_vec[SRC_CLK] = clk_sup_fail;
   end

   srh_stretch #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .clk    (osc_clk),
      .rst_n  (por_n),
      .trig   (|trig_vec),
      .active (hold_act)
   );

   srh_cause #(.N(NSRC), .POR_IDX(SRC_POR)) u_cause (
      .clk     (osc_clk),
      .rst_n   (por_n),
      .set_vec (trig_vec),
      .clr_vec (cause_clr),
      .flags   (cause_flags)
   );

   assign rst_int = por_busy | async_s[A_EXT] | async_s[A_LVD] | hold_act;
   assign sys_rst = rst_int;

   // control bits: forced to their reset values on every reset
   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n) begin
         sw_bit <= 1'b1;
         ws_sel <= '1;
      end else if (rst_int) begin
         sw_bit <= 1'b1;
         ws_sel <= '1;
      end else begin
         if (sw_wr) sw_bit <= sw_wdata;
         if (ws_wr) ws_sel <= ws_wdata;
      end
   end
endmodule

// File: rtl/sysreset_hub_chk.sv
module sysreset_hub_chk #(
   parameter int WAIT_LOG2 = 16,
   parameter int WS_W      = 2
) (
   input logic            osc_clk,
   input logic            por_n,
   input logic            ext_rst_n,
   input logic            lvd_det,
   input logic            wdt_ovf,
   input logic            cpu_det_ovf,
   input logic            clk_sup_fail,
   input logic            sw_wr,
   input logic            sw_wdata,
   input logic            sw_bit,
   input logic [WS_W-1:0] ws_sel,
   input logic            clr_wdt,
   input logic            flag_wdt,
   input logic            flag_por,
   input logic            sys_rst
);
   localparam int CW = WAIT_LOG2 + 2;
   localparam logic [CW-1:0] LIMIT = CW'((64'd1 << WAIT_LOG2) + 64'd1);

   // edges since power-on release, saturating
   logic [CW-1:0] since_por;
   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n)               since_por <= '0;
      else if (since_por != '1) since_por <= since_por + 1'b1;
   end

   AST_POR_WAIT_HELD: assert property (@(posedge osc_clk) disable iff (!por_n)
      (since_por <= LIMIT) |-> sys_rst);                                  // R2 R8
   AST_SYNC_SRC_RST: assert property (@(posedge osc_clk) disable iff (!por_n)
      (wdt_ovf || cpu_det_ovf || clk_sup_fail) |=> sys_rst);              // R3
   AST_ASYNC_IMMEDIATE: assert property (@(posedge osc_clk) disable iff (!por_n)
      (!ext_rst_n || lvd_det) |-> sys_rst);                               // R4
   AST_POR_FLAG_SOURCE: assert property (@(posedge osc_clk) disable iff (!por_n)
      !$rose(flag_por));                                                  // R5
   AST_FLAG_CLEAR: assert property (@(posedge osc_clk) disable iff (!por_n)
      (clr_wdt && !wdt_ovf) |=> !flag_wdt);                               // R5
   AST_WS_FORCED: assert property (@(posedge osc_clk) disable iff (!por_n)
      (sys_rst && $past(sys_rst)) |-> (ws_sel == '1));                    // R6
   AST_SW_FIRE: assert property (@(posedge osc_clk) disable iff (!por_n)
      (sw_wr && !sw_wdata && !sys_rst) |=> (sys_rst && !sw_bit));         // R7
   AST_SW_ONE_SHOT: assert property (@(posedge osc_clk) disable iff (!por_n)
      !sw_bit |=> sw_bit);                                                // R7
endmodule

bind sysreset_hub sysreset_hub_chk #(.WAIT_LOG2(WAIT_LOG2), .WS_W(WS_W)) u_chk (
   .osc_clk      (osc_clk),
   .por_n        (por_n),
   .ext_rst_n    (ext_rst_n),
   .lvd_det      (lvd_det),
   .wdt_ovf      (wdt_ovf),
   .cpu_det_ovf  (cpu_det_ovf),
   .clk_sup_fail (clk_sup_fail),
   .sw_wr        (sw_wr),
   .sw_wdata     (sw_wdata),
   .sw_bit       (sw_bit),
   .ws_sel       (ws_sel),
   .clr_wdt      (cause_clr[1]),
   .flag_wdt     (cause_flags[1]),
   .flag_por     (cause_flags[0]),
   .sys_rst      (sys_rst)
);

// File: tb/sysreset_hub_bench.sv
module sysreset_hub_bench;
   localparam int WAITC = 65536;
   localparam int HOLDC = 8;
   localparam int SYNCN = 2;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic       por_n = 1'b0, ext_n = 1'b1, lvd = 1'b0;
   logic       wdt = 1'b0, cpu = 1'b0, clkf = 1'b0;
   logic       sw_wr = 1'b0, sw_wdata = 1'b1;
   logic       ws_wr = 1'b0;
   logic [1:0] ws_wdata = 2'b00;
   logic [6:0] clr = 7'b0;
   logic       sw_bit, sys_rst;
   logic [1:0] ws_sel;
   logic [6:0] flags;

   sysreset_hub u_sysreset_hub (
      .osc_clk(clk), .por_n(por_n), .ext_rst_n(ext_n), .lvd_det(lvd),
      .wdt_ovf(wdt), .cpu_det_ovf(cpu), .clk_sup_fail(clkf),
      .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_bit(sw_bit),
      .ws_wr(ws_wr), .ws_wdata(ws_wdata), .ws_sel(ws_sel),
      .cause_clr(clr), .cause_flags(flags), .sys_rst(sys_rst)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0, m_on = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [6:0] m_flags;
   logic [1:0] m_ws;
   logic       m_sw;
   int m_por_cd, m_left, m_ext_cd, m_lvd_cd, m_hold;

   function automatic logic m_rst();
      return !por_n || m_por_cd > 0 || m_left > 0 || !ext_n || m_ext_cd > 0 ||
             lvd || m_lvd_cd > 0 || m_hold > 0;
   endfunction

   task automatic m_por_reset();
      m_flags = 7'b0000001; m_ws = 2'b11; m_sw = 1'b1; m_hold = 0;
      m_por_cd = SYNCN; m_left = WAITC;
   endtask

   initial begin m_ext_cd = 0; m_lvd_cd = 0; m_por_reset(); end
   always @(negedge por_n) m_por_reset();

   always @(posedge clk) begin : mdl
      logic pre, ext_act, lvd_act, por_act, fire, trig;
      logic [6:0] srcs;
      pre     = m_rst();
      ext_act = !ext_n || m_ext_cd > 0;
      lvd_act = lvd || m_lvd_cd > 0;
      por_act = m_por_cd > 0;
      if (!ext_n) m_ext_cd = SYNCN; else if (m_ext_cd > 0) m_ext_cd--;
      if (lvd)    m_lvd_cd = SYNCN; else if (m_lvd_cd > 0) m_lvd_cd--;
      if (!por_n) m_por_reset();
      else begin
         fire = sw_wr && !sw_wdata && !pre;
         trig = wdt || ext_act || fire || lvd_act || cpu || clkf;
         if (m_por_cd > 0) m_por_cd--;
         if (por_act) m_left = WAITC; else if (m_left > 0) m_left--;
         if (trig) m_hold = HOLDC; else if (m_hold > 0) m_hold--;
         srcs = {clkf, cpu, lvd_act, fire, ext_act, wdt, 1'b0};
         for (int i = 0; i < 7; i++) begin
            if (srcs[i]) m_flags[i] = 1'b1;
            else if (clr[i]) m_flags[i] = 1'b0;
         end
         if (pre) begin m_sw = 1'b1; m_ws = 2'b11; end
         else begin
            if (sw_wr) m_sw = sw_wdata;
            if (ws_wr) m_ws = ws_wdata;
         end
      end
   end

   always @(negedge clk) begin
      if (m_on && !done) begin
         chk("R2 model sys_rst", sys_rst, m_rst());
         chk("R5 model cause_flags", flags, m_flags);
         chk("R6 model ws_sel", ws_sel, m_ws);
         chk("R7 model sw_bit", sw_bit, m_sw);
      end
   end

   task automatic to_edge(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // ---------------- directed sequence ----------------
   initial begin
      int rel, e, e2, c;
      repeat (3) @(negedge clk);
      m_on = 1;
      chk("R1 sys_rst in POR", sys_rst, 1);
      chk("R1 flags in POR", flags, 7'b0000001);
      chk("R1 ws_sel in POR", ws_sel, 2'b11);
      chk("R1 sw_bit in POR", sw_bit, 1);

      #1 por_n = 1'b1; rel = cyc;
      to_edge(rel + 20);
      #1 ws_wr = 1'b1; ws_wdata = 2'b00; sw_wr = 1'b1; sw_wdata = 1'b0;
      @(negedge clk); #1 ws_wr = 1'b0; sw_wr = 1'b0; sw_wdata = 1'b1;
      @(negedge clk);
      chk("R6 ws write ignored in reset", ws_sel, 2'b11);
      chk("R7 sw write ignored in reset", flags[3], 0);
      to_edge(rel + WAITC + 1);
      chk("R2 held at last wait edge", sys_rst, 1);
      @(negedge clk);
      chk("R2 released after wait", sys_rst, 0);

      #1 ws_wr = 1'b1; ws_wdata = 2'b01;
      @(negedge clk);
      chk("R6 ws write outside reset", ws_sel, 2'b01);
      #1 ws_wr = 1'b0;

      // watchdog pulse
      @(negedge clk); #1 wdt = 1'b1; e = cyc + 1;
      @(negedge clk);
      chk("R3 wdt asserts reset", sys_rst, 1);
      chk("R5 wdt flag", flags[1], 1);
      #1 wdt = 1'b0;
      @(negedge clk);
      chk("R6 ws forced by reset", ws_sel, 2'b11);
      to_edge(e + 7); chk("R3 held 7 edges", sys_rst, 1);
      to_edge(e + 8); chk("R3 released at 8", sys_rst, 0);

      // retrigger during hold
      @(negedge clk); #1 cpu = 1'b1; e = cyc + 1;
      @(negedge clk); #1 cpu = 1'b0;
      to_edge(e + 3); #1 clkf = 1'b1; e2 = cyc + 1;
      @(negedge clk); #1 clkf = 1'b0;
      to_edge(e + 8);  chk("R9 hold restarted", sys_rst, 1);
      to_edge(e2 + 7); chk("R9 held after retrigger", sys_rst, 1);
      to_edge(e2 + 8); chk("R9 release after retrigger", sys_rst, 0);
      chk("R5 cpu and clock flags", flags[6:5], 2'b11);

      // clearing
      #1 clr = 7'b1111110;
      @(negedge clk); chk("R5 clear others", flags, 7'b0000001);
      #1 clr = 7'b0000001;
      @(negedge clk); chk("R5 clear por flag", flags, 7'b0000000);
      #1 clr = 7'b0000010; wdt = 1'b1;
      @(negedge clk); chk("R5 set beats clear", flags[1], 1);
      #1 clr = 7'b0; wdt = 1'b0;
      to_edge(cyc + 9);
      #1 clr = 7'b0000010;
      @(negedge clk); #1 clr = 7'b0;

      // firmware request
      #1 sw_wr = 1'b1; sw_wdata = 1'b1;
      @(negedge clk);
      chk("R7 write 1 no reset", sys_rst, 0);
      chk("R7 write 1 readback", sw_bit, 1);
      #1 sw_wr = 1'b0;
      @(negedge clk); chk("R7 write 1 no flag", flags[3], 0);
      #1 sw_wr = 1'b1; sw_wdata = 1'b0; e = cyc + 1;
      @(negedge clk);
      chk("R7 write 0 resets", sys_rst, 1);
      chk("R7 bit reads 0", sw_bit, 0);
      chk("R7 sw flag", flags[3], 1);
      #1 sw_wr = 1'b0; sw_wdata = 1'b1;
      @(negedge clk); chk("R7 bit back to 1", sw_bit, 1);
      to_edge(e + 8); chk("R7 release", sys_rst, 0);

      // external pin
      @(negedge clk); #1 ext_n = 1'b0; #2;
      chk("R4 pin asserts at once", sys_rst, 1);
      repeat (3) @(negedge clk);
      #1 ext_n = 1'b1; c = cyc;
      to_edge(c + 9);  chk("R4 pin held", sys_rst, 1);
      to_edge(c + 10); chk("R4 pin release", sys_rst, 0);
      chk("R5 pin flag", flags[2], 1);

      // low voltage
      @(negedge clk); #1 lvd = 1'b1; #2;
      chk("R4 lvd asserts at once", sys_rst, 1);
      repeat (3) @(negedge clk);
      #1 lvd = 1'b0; c = cyc;
      to_edge(c + 9);  chk("R4 lvd held", sys_rst, 1);
      to_edge(c + 10); chk("R4 lvd release", sys_rst, 0);
      chk("R5 lvd flag", flags[4], 1);

      // power-on restart
      @(negedge clk); #1 por_n = 1'b0; #2;
      chk("R5 por clears others", flags, 7'b0000001);
      chk("R1 reset on por", sys_rst, 1);
      @(negedge clk); chk("R1 ws on por", ws_sel, 2'b11);
      #1 por_n = 1'b1; rel = cyc;
      to_edge(rel + 1000);
      #1 por_n = 1'b0;
      @(negedge clk); #1 por_n = 1'b1; rel = cyc;
      to_edge(rel + WAITC + 1);
      chk("R8 full wait after restart", sys_rst, 1);
      @(negedge clk);
      chk("R8 release after restart", sys_rst, 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule